// File: doc/BRIEF.md
# Byte-Bus 16-bit Timer Register File

This block holds a 16-bit up-counter, a 16-bit compare register and a 16-bit capture register, all reached through an 8-bit register bus. Each 16-bit register has a low-byte address and a high-byte address. All three share one temporary byte register, so a 16-bit value can be moved in two byte accesses without tearing.

A write presents the high byte first. That byte is parked in the temporary register, and the low-byte write then commits both bytes in the same cycle. A read takes the low byte first. That access copies the matching high byte into the temporary register, and the later high-byte read returns that frozen copy.

The counter advances on a timer-clock enable. A one-cycle pulse marks the counter stepping onto the compare value. A capture strobe copies the counter into the capture register and raises a sticky flag. The bus is a plain register port with no back-pressure: `rdata` follows `addr` combinationally, and every access completes in the cycle it is presented.

Top module: `tmr16_regs`

## Requirements
- R1: After reset, the counter, compare, capture and temporary registers are all zero, and `cmp_match` and `cap_flag` are low. Address map: 0 counter low, 1 counter high, 2 compare low, 3 compare high, 4 capture low, 5 capture high. Addresses 6 and 7 read 0 and ignore writes.
- R2: A write to address 3 stores the byte only in the temporary register. The compare register is unchanged.
- R3: A write to address 2 loads the compare register with {temporary, written byte} in one cycle. If the low byte is written without a fresh high byte, the stale temporary byte is used as the upper half.
- R4: A read of address 0 returns the counter's low byte and copies the counter's high byte into the temporary register. A read of address 1 returns the temporary register, so reading high before low returns a stale upper byte.
- R5: Counter, compare and capture accesses all use one shared temporary register. For example, a write to address 1 followed by a write to address 2 loads that byte into the compare register's upper half.
- R6: A write to address 1 then address 0 loads the counter with {high, low}. Counting resumes from that value on the next `tick_en`.
- R7: When a write to address 0 and `tick_en` occur in the same cycle, the written value is loaded and that cycle's count is dropped.
- R8: Reads of addresses 2 and 3 return the compare register's low and high bytes directly and leave the temporary register unchanged.
- R9: `cmp_match` is high for exactly the one cycle after a `tick_en` step (with no counter write) moves the counter onto the compare value. A counter load onto the compare value gives no pulse.
- R10: `cap_strobe` copies the counter's current value into the capture register. A read of address 4 returns the capture low byte and copies its high byte into the temporary register. A read of address 5 returns the temporary register. Writes to addresses 4 and 5 are ignored.
- R11: `cap_flag` sets on `cap_strobe` and clears on a read of address 4. If both happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Bus read strobe for this cycle |
| wr_en | input | 1 | Bus write strobe for this cycle |
| addr | input | 3 | Byte register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from `addr` |
| tick_en | input | 1 | Timer-clock enable, one count per high cycle |
| cap_strobe | input | 1 | Capture request |
| cmp_match | output | 1 | One-cycle compare pulse |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle, since the shared temporary register gives no defined priority between a read-side copy and a write-side park. The bench therefore issues at most one bus operation per cycle, in both the directed sequences and the random phase. Inside that limit, ticks and capture strobes are free to land on any cycle, including cycles with bus accesses.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [2:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_CMP_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_CAP_LO = 3'd4,
    A_CAP_HI = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tmr16_bus_bridge.sv
module tmr16_bus_bridge
  import tmr16_pkg::*;
#(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  input  logic [WW-1:0] cnt,
  input  logic [WW-1:0] cmp,
  input  logic [WW-1:0] cap,
  output logic [BW-1:0] temp_o,
  output logic          cnt_load,
  output logic          cmp_load,
  output logic [WW-1:0] load_val,
  output logic          cap_rd
);
  logic [BW-1:0] temp_q;
  logic          park_hi;
  logic          snap_cnt;

  always_comb begin
    park_hi  = wr_en && (addr == A_CNT_HI || addr == A_CMP_HI);
    cnt_load = wr_en && (addr == A_CNT_LO);
    cmp_load = wr_en && (addr == A_CMP_LO);
    snap_cnt = rd_en && (addr == A_CNT_LO);
    cap_rd   = rd_en && (addr == A_CAP_LO);
    load_val = {temp_q, wdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        temp_q <= '0;
    else if (park_hi)  temp_q <= wdata;
    else if (snap_cnt) temp_q <= cnt[WW-1:BW];
    else if (cap_rd)   temp_q <= cap[WW-1:BW];
  end

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = cnt[BW-1:0];
      A_CNT_HI: rdata = temp_q;
      A_CMP_LO: rdata = cmp[BW-1:0];
      A_CMP_HI: rdata = cmp[WW-1:BW];
      A_CAP_LO: rdata = cap[BW-1:0];
      A_CAP_HI: rdata = temp_q;
      default:  rdata = '0;
    endcase
  end

  assign temp_o = temp_q;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cnt_load,
  input  logic          cmp_load,
  input  logic [WW-1:0] load_val,
  input  logic          cap_strobe,
  input  logic          cap_clr,
  output logic [WW-1:0] cnt,
  output logic [WW-1:0] cmp,
  output logic [WW-1:0] cap,
  output logic          cmp_match,
  output logic          cap_flag
);
  logic [WW-1:0] cnt_q, cmp_q, cap_q, cnt_inc;
  logic          match_q, flag_q, step;

  assign cnt_inc = cnt_q + 1'b1;
  assign step    = tick_en && !cnt_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_q   <= '0;
      cap_q   <= '0;
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cnt_load)  cnt_q <= load_val;
      else if (step) cnt_q <= cnt_inc;
      if (cmp_load)  cmp_q <= load_val;
      if (cap_strobe) cap_q <= cnt_q;
      match_q <= step && (cnt_inc == cmp_q);
      if (cap_strobe)   flag_q <= 1'b1;
      else if (cap_clr) flag_q <= 1'b0;
    end
  end

  assign cnt       = cnt_q;
  assign cmp       = cmp_q;
  assign cap       = cap_q;
  assign cmp_match = match_q;
  assign cap_flag  = flag_q;
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs #(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  input  logic          tick_en,
  input  logic          cap_strobe,
  output logic          cmp_match,
  output logic          cap_flag
);
  logic [WW-1:0] cnt_w, cmp_w, cap_w, load_w;
  logic [BW-1:0] temp_w;
  logic          cnt_load_w, cmp_load_w, cap_rd_w;

  tmr16_bus_bridge #(.BW(BW)) u_bridge (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt(cnt_w), .cmp(cmp_w), .cap(cap_w),
    .temp_o(temp_w), .cnt_load(cnt_load_w), .cmp_load(cmp_load_w),
    .load_val(load_w), .cap_rd(cap_rd_w)
  );

  tmr16_core #(.WW(WW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_load(cnt_load_w),
    .cmp_load(cmp_load_w), .load_val(load_w), .cap_strobe(cap_strobe),
    .cap_clr(cap_rd_w), .cnt(cnt_w), .cmp(cmp_w), .cap(cap_w),
    .cmp_match(cmp_match), .cap_flag(cap_flag)
  );
endmodule

// File: rtl/tmr16_regs_chk.sv
module tmr16_regs_chk #(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [BW-1:0] wdata,
  input logic          tick_en,
  input logic          cap_strobe,
  input logic          cmp_match,
  input logic          cap_flag,
  input logic [WW-1:0] cnt,
  input logic [WW-1:0] cmp,
  input logic [WW-1:0] cap,
  input logic [BW-1:0] temp
);
  assert_one_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  assert_cmp_hi_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> (cmp == $past(cmp) && temp == $past(wdata)));

  assert_cmp_lo_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> cmp == {$past(temp), $past(wdata)});

  assert_cnt_lo_snap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0) |=> temp == $past(cnt[WW-1:BW]));

  assert_cnt_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> cnt == {$past(temp), $past(wdata)});

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !(wr_en && addr == 3'd0)) |=> cnt == $past(cnt) + 1'b1);

  assert_match_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |-> cnt == cmp);

  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> (cap == $past(cnt) && cap_flag));

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd4 && !cap_strobe) |=> !cap_flag);
endmodule

bind tmr16_regs tmr16_regs_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .tick_en(tick_en), .cap_strobe(cap_strobe),
  .cmp_match(cmp_match), .cap_flag(cap_flag), .cnt(cnt_w), .cmp(cmp_w),
  .cap(cap_w), .temp(temp_w)
);

// File: tb/tb_tmr16_regs.sv
module tb_tmr16_regs;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0, tick_en = 1'b0, cap_strobe = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cmp_match, cap_flag;

  int total = 0, bad = 0;
  logic [15:0] m_cnt, m_cmp, m_cap;
  logic [7:0]  m_temp, last_rd;
  logic        m_match, m_flag, last_match, last_flag;

  always #(CLK_P/2) clk = ~clk;

  tmr16_regs dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .cap_strobe(cap_strobe),
    .cmp_match(cmp_match), .cap_flag(cap_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[7:0];
      3'd1: return m_temp;
      3'd2: return m_cmp[7:0];
      3'd3: return m_cmp[15:8];
      3'd4: return m_cap[7:0];
      3'd5: return m_temp;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [2:0] a,
                      input logic [7:0] d, input logic tk, input logic st, input string tag);
    logic [15:0] n_cnt, n_cmp, n_cap;
    logic [7:0]  n_temp;
    logic        n_match, n_flag, ld;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = d; tick_en = tk; cap_strobe = st;
    #1;
    last_rd = rdata; last_match = cmp_match; last_flag = cap_flag;
    if (rd) chk(rdata == exp_rd(a), tag, {8'h0, rdata}, {8'h0, exp_rd(a)});
    chk(cmp_match == m_match, "R9 match pulse", {15'h0, cmp_match}, {15'h0, m_match});
    chk(cap_flag == m_flag, "R11 capture flag", {15'h0, cap_flag}, {15'h0, m_flag});
    ld = wr && a == 3'd0;
    n_temp = m_temp;
    if (wr && (a == 3'd1 || a == 3'd3)) n_temp = d;
    else if (rd && a == 3'd0) n_temp = m_cnt[15:8];
    else if (rd && a == 3'd4) n_temp = m_cap[15:8];
    n_cnt = ld ? {m_temp, d} : (tk ? m_cnt + 16'd1 : m_cnt);
    n_cmp = (wr && a == 3'd2) ? {m_temp, d} : m_cmp;
    n_cap = st ? m_cnt : m_cap;
    n_match = tk && !ld && (m_cnt + 16'd1 == m_cmp);
    n_flag = st ? 1'b1 : ((rd && a == 3'd4) ? 1'b0 : m_flag);
    m_cnt = n_cnt; m_cmp = n_cmp; m_cap = n_cap; m_temp = n_temp;
    m_match = n_match; m_flag = n_flag;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d, 1'b0, 1'b0, "write");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    step(1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0, tag);
  endtask
  task automatic tick();
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, "tick");
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_cnt = '0; m_cmp = '0; m_cap = '0; m_temp = '0; m_match = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(i[2:0], "R1 reset read");
      chk(last_rd == 8'h00, "R1 reset zero", {8'h0, last_rd}, 16'h0);
    end
    // R2 high byte only parks
    wr(3'd3, 8'h12);
    rd(3'd3, "R2 compare unchanged");
    chk(last_rd == 8'h00, "R2 compare high unchanged", {8'h0, last_rd}, 16'h0);
    // R3 atomic commit, R8 direct read
    wr(3'd2, 8'h34);
    rd(3'd3, "R8 compare high"); chk(last_rd == 8'h12, "R3 hi", {8'h0, last_rd}, 16'h12);
    rd(3'd2, "R8 compare low");  chk(last_rd == 8'h34, "R3 lo", {8'h0, last_rd}, 16'h34);
    // R3 torn write: low only, stale upper byte
    wr(3'd2, 8'h56);
    rd(3'd3, "R3 torn"); chk(last_rd == 8'h12, "R3 torn hi", {8'h0, last_rd}, 16'h12);
    rd(3'd2, "R3 torn"); chk(last_rd == 8'h56, "R3 torn lo", {8'h0, last_rd}, 16'h56);
    // R6/R7 counter load beats tick
    step(1'b0, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0, "R7 hi");
    step(1'b0, 1'b1, 3'd0, 8'hFE, 1'b1, 1'b0, "R7 lo");
    rd(3'd0, "R7 load"); chk(last_rd == 8'hFE, "R7 load wins", {8'h0, last_rd}, 16'hFE);
    tick(); tick();
    rd(3'd0, "R6 lo"); chk(last_rd == 8'h00, "R6 resume lo", {8'h0, last_rd}, 16'h00);
    rd(3'd1, "R4 hi"); chk(last_rd == 8'h01, "R4 snapshot hi", {8'h0, last_rd}, 16'h01);
    // R4 torn read: high before low
    tick();
    wr(3'd1, 8'h01); wr(3'd0, 8'hFF);
    rd(3'd0, "R4 lo first"); chk(last_rd == 8'hFF, "R4 lo", {8'h0, last_rd}, 16'hFF);
    tick();
    rd(3'd1, "R4 torn"); chk(last_rd == 8'h01, "R4 stale hi", {8'h0, last_rd}, 16'h01);
    rd(3'd0, "R4 torn"); chk(last_rd == 8'h00, "R4 torn lo", {8'h0, last_rd}, 16'h00);
    // R5 shared temporary across registers
    wr(3'd1, 8'hAB); wr(3'd2, 8'hCD);
    rd(3'd3, "R5"); chk(last_rd == 8'hAB, "R5 shared temp", {8'h0, last_rd}, 16'hAB);
    rd(3'd0, "R5 cnt"); rd(3'd1, "R5 cnt hi");
    chk(last_rd == 8'h02, "R5 counter untouched", {8'h0, last_rd}, 16'h02);
    // R9 match pulse
    wr(3'd3, 8'h02); wr(3'd2, 8'h05);
    repeat (5) tick();
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R9 idle");
    chk(last_match == 1'b1, "R9 pulse", {15'h0, last_match}, 16'h1);
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R9 idle");
    chk(last_match == 1'b0, "R9 one cycle", {15'h0, last_match}, 16'h0);
    wr(3'd1, 8'h02); wr(3'd0, 8'h04); wr(3'd0, 8'h05);
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R9 load");
    chk(last_match == 1'b0, "R9 no pulse on load", {15'h0, last_match}, 16'h0);
    // R10 capture, R11 flag
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, "R10 strobe");
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    chk(last_flag == 1'b1, "R11 set", {15'h0, last_flag}, 16'h1);
    rd(3'd4, "R10 cap lo"); chk(last_rd == 8'h05, "R10 cap lo", {8'h0, last_rd}, 16'h05);
    rd(3'd5, "R10 cap hi"); chk(last_rd == 8'h02, "R10 cap hi", {8'h0, last_rd}, 16'h02);
    chk(last_flag == 1'b0, "R11 cleared", {15'h0, last_flag}, 16'h0);
    step(1'b1, 1'b0, 3'd4, 8'h00, 1'b0, 1'b1, "R11 both");
    rd(3'd2, "R11 after");
    chk(last_flag == 1'b1, "R11 strobe wins", {15'h0, last_flag}, 16'h1);
    // constrained random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [2:0] a;
      op = $urandom % 100;
      a = 3'($urandom % 8);
      step(op < 40, op >= 40 && op < 65, a, 8'($urandom), ($urandom % 3) != 0,
           ($urandom % 16) == 0, "R4 R10 random read");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule